// File: doc/BRIEF.md
# Multi-Page-Size TLB Translator

This block is a four-entry, fully associative address translation cache. A requester presents a 32-bit virtual address together with the current 8-bit address-space tag. When the translation-enable input is high, the block searches every loaded entry at once and returns a 29-bit physical address with that page's attributes. When the enable is low, the block passes the low 29 bits of the address through untouched.

Each entry has its own page size: 1 KB, 4 KB, 64 KB or 1 MB. The page size sets how many virtual address bits are compared and how many low bits are copied straight into the result. Besides the cacheable and write-through bits, an entry carries a 3-bit bus-timing field and a 3-bit space field, and it can be marked as lying in card-interface space. If a hit lands on a card-space page that is cacheable but not write-through, the block raises a conflict flag.

Entries are loaded through a single-cycle write port. The lookup path is purely combinational from the stored entries. Neither port has back-pressure: a lookup result is valid in the same cycle the address is presented, and a write is always accepted, so no ready signal exists on either side.

Top module: `mmu_xlate_tlb`

## Requirements
- R1: After reset every entry is invalid, so any lookup with translation enabled reports a miss.
- R2: A write through the load port, selected by `wr_idx`, replaces that entry at the next rising clock edge. A lookup made in the same cycle as the write still sees the old contents.
- R3: An entry hits only if its valid bit is set, its address-space tag equals `lk_asid`, and its tag bits match the virtual address.
- R4: The entry's size code selects the compared virtual bits: code 0 compares bits [31:10] (1 KB), code 1 compares [31:12] (4 KB), code 2 compares [31:16] (64 KB) and code 3 compares [31:20] (1 MB).
- R5: On a hit, the physical address takes the entry's physical page bits above the page boundary and the virtual address bits below it. `wr_ppn` holds physical bits [28:10].
- R6: On a hit, the cacheable, write-through, timing and space outputs show the entry's stored values. When there is no hit they are all zero, and `lk_paddr` is zero on a miss.
- R7: With translation enabled, `lk_miss` is high exactly when no entry hits. `lk_hit` and `lk_miss` are never high together.
- R8: With `xlate_en` low, `lk_paddr` equals `lk_vaddr[28:0]`, and `lk_hit`, `lk_miss` and all attribute outputs are zero.
- R9: `lk_attr_conflict` is high exactly when there is a hit on an entry whose card-space, cacheable and write-through bits are 1, 1 and 0.
- R10: If more than one entry hits, the entry with the lowest index supplies the result.
- R11: Writing an entry with `wr_valid` = 0 removes it from matching from the next edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xlate_en | input | 1 | Translation enable |
| lk_vaddr | input | 32 | Lookup virtual address |
| lk_asid | input | 8 | Current address-space tag |
| lk_hit | output | 1 | An entry matched |
| lk_miss | output | 1 | Translation enabled, no entry matched |
| lk_paddr | output | 29 | Physical address |
| lk_cacheable | output | 1 | Hit page is cacheable |
| lk_wthru | output | 1 | Hit page is write-through |
| lk_timing | output | 3 | Hit page bus timing |
| lk_space | output | 3 | Hit page space attribute |
| lk_attr_conflict | output | 1 | Card page cacheable without write-through |
| wr_en | input | 1 | Load an entry |
| wr_idx | input | 2 | Entry index to load |
| wr_valid | input | 1 | Valid bit for the new entry |
| wr_vpn | input | 22 | Virtual bits [31:10] |
| wr_asid | input | 8 | Address-space tag |
| wr_size | input | 2 | Page size code |
| wr_ppn | input | 19 | Physical bits [28:10] |
| wr_cache | input | 1 | Cacheable bit |
| wr_wthru | input | 1 | Write-through bit |
| wr_card | input | 1 | Page lies in card-interface space |
| wr_timing | input | 3 | Bus timing field |
| wr_space | input | 3 | Space attribute field |

## Verification
The hardest cases to reach from the ports are lookups that sit exactly on a page boundary. The address differs from an entry's tag in a single bit, either just above or just below the boundary that the entry's size code sets. To reach them, the bench loads one entry of each size and sweeps lookups that flip each bit next to the four boundaries. It also loads overlapping pages of different sizes, which exercises the lowest-index rule. A behavioural reference model checks every lookup, including one made in the same cycle as a write.

// File: rtl/tlb_pkg.sv
`timescale 1ns/1ps
package tlb_pkg;
  localparam int VA_W      = 32;
  localparam int PA_W      = 29;
  localparam int ASID_W    = 8;
  localparam int MIN_SHIFT = 10;
  localparam int VPN_W     = VA_W - MIN_SHIFT;
  localparam int PPN_W     = PA_W - MIN_SHIFT;
  localparam int TIM_W     = 3;
  localparam int SPC_W     = 3;

  typedef struct packed {
    logic              valid;
    logic [VPN_W-1:0]  vpn;
    logic [ASID_W-1:0] asid;
    logic [1:0]        size;
    logic [PPN_W-1:0]  ppn;
    logic              cache;
    logic              wthru;
    logic              card;
    logic [TIM_W-1:0]  timing;
    logic [SPC_W-1:0]  space;
  } tlb_ent_t;

  // Low page-number bits that belong to the in-page offset for a size code.
  function automatic logic [PPN_W-1:0] pg_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    return '0;
      2'd1:    return PPN_W'(10'h003);
      2'd2:    return PPN_W'(10'h03F);
      default: return PPN_W'(10'h3FF);
    endcase
  endfunction
endpackage

// File: rtl/tlb_entry_store.sv
`timescale 1ns/1ps
module tlb_entry_store
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  tlb_ent_t         wr_ent,
  output tlb_ent_t         ents [ENTRIES]
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    tlb_ent_t ent_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            ent_q <= '0;
      else if (wr_en && wr_idx == IDX_W'(g)) ent_q <= wr_ent;
    end
    assign ents[g] = ent_q;

    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx == IDX_W'(g)) |=> (ents[g] == $past(wr_ent)));
    a_r2_hold_unwritten: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_idx == IDX_W'(g)) |=> $stable(ents[g]));
  end
endmodule

// File: rtl/tlb_match.sv
`timescale 1ns/1ps
module tlb_match
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 4
) (
  input  tlb_ent_t          ents [ENTRIES],
  input  logic [VPN_W-1:0]  va_vpn,
  input  logic [ASID_W-1:0] cur_asid,
  output logic [ENTRIES-1:0] hit_vec
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    logic [VPN_W-1:0] ign;
    logic             tag_eq;
    assign ign    = {{(VPN_W-PPN_W){1'b0}}, pg_mask(ents[g].size)};
    assign tag_eq = ((va_vpn ^ ents[g].vpn) & ~ign) == '0;
    assign hit_vec[g] = ents[g].valid && tag_eq && (ents[g].asid == cur_asid);
  end
endmodule

// File: rtl/tlb_select.sv
`timescale 1ns/1ps
module tlb_select
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 4
) (
  input  tlb_ent_t           ents [ENTRIES],
  input  logic [ENTRIES-1:0] hit_vec,
  input  logic               xlate_en,
  input  logic [PA_W-1:0]    va_low,
  output tlb_ent_t           sel_ent,
  output logic               any_hit,
  output logic               hit,
  output logic               miss,
  output logic [PA_W-1:0]    paddr
);
  logic [PPN_W-1:0] keep;
  logic [PPN_W-1:0] page_bits;

  // Walk from the top index down so the lowest matching index wins.
  always_comb begin
    sel_ent = '0;
    any_hit = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        sel_ent = ents[i];
        any_hit = 1'b1;
      end
    end
  end

  assign keep      = pg_mask(sel_ent.size);
  assign page_bits = (sel_ent.ppn & ~keep) | (va_low[PA_W-1:MIN_SHIFT] & keep);
  assign hit       = xlate_en && any_hit;
  assign miss      = xlate_en && !any_hit;

  always_comb begin
    if (!xlate_en)    paddr = va_low;
    else if (any_hit) paddr = {page_bits, va_low[MIN_SHIFT-1:0]};
    else              paddr = '0;
  end
endmodule

// File: rtl/mmu_xlate_tlb.sv
`timescale 1ns/1ps
module mmu_xlate_tlb
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 4,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 xlate_en,
  input  logic [VA_W-1:0]      lk_vaddr,
  input  logic [ASID_W-1:0]    lk_asid,
  output logic                 lk_hit,
  output logic                 lk_miss,
  output logic [PA_W-1:0]      lk_paddr,
  output logic                 lk_cacheable,
  output logic                 lk_wthru,
  output logic [TIM_W-1:0]     lk_timing,
  output logic [SPC_W-1:0]     lk_space,
  output logic                 lk_attr_conflict,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic                 wr_valid,
  input  logic [VPN_W-1:0]     wr_vpn,
  input  logic [ASID_W-1:0]    wr_asid,
  input  logic [1:0]           wr_size,
  input  logic [PPN_W-1:0]     wr_ppn,
  input  logic                 wr_cache,
  input  logic                 wr_wthru,
  input  logic                 wr_card,
  input  logic [TIM_W-1:0]     wr_timing,
  input  logic [SPC_W-1:0]     wr_space
);
  tlb_ent_t           wr_ent;
  tlb_ent_t           ents [ENTRIES];
  tlb_ent_t           sel_ent;
  logic [ENTRIES-1:0] hit_vec;
  logic               any_hit;

  always_comb begin
    wr_ent.valid  = wr_valid;
    wr_ent.vpn    = wr_vpn;
    wr_ent.asid   = wr_asid;
    wr_ent.size   = wr_size;
    wr_ent.ppn    = wr_ppn;
    wr_ent.cache  = wr_cache;
    wr_ent.wthru  = wr_wthru;
    wr_ent.card   = wr_card;
    wr_ent.timing = wr_timing;
    wr_ent.space  = wr_space;
  end

  tlb_entry_store #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_ent(wr_ent), .ents(ents)
  );

  tlb_match #(.ENTRIES(ENTRIES)) u_match (
    .ents(ents), .va_vpn(lk_vaddr[VA_W-1:MIN_SHIFT]),
    .cur_asid(lk_asid), .hit_vec(hit_vec)
  );

  tlb_select #(.ENTRIES(ENTRIES)) u_sel (
    .ents(ents), .hit_vec(hit_vec), .xlate_en(xlate_en),
    .va_low(lk_vaddr[PA_W-1:0]), .sel_ent(sel_ent), .any_hit(any_hit),
    .hit(lk_hit), .miss(lk_miss), .paddr(lk_paddr)
  );

  assign lk_cacheable     = lk_hit && sel_ent.cache;
  assign lk_wthru         = lk_hit && sel_ent.wthru;
  assign lk_timing        = lk_hit ? sel_ent.timing : '0;
  assign lk_space         = lk_hit ? sel_ent.space  : '0;
  assign lk_attr_conflict = lk_hit && sel_ent.card && sel_ent.cache && !sel_ent.wthru;

  a_r8_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    !xlate_en |-> (lk_paddr == lk_vaddr[PA_W-1:0] && !lk_hit && !lk_miss));
  a_r7_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lk_hit, lk_miss}));
  a_r7_decided: assert property (@(posedge clk) disable iff (!rst_n)
    xlate_en |-> (lk_hit != lk_miss));
  a_r3_tag_and_asid: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (sel_ent.valid && sel_ent.asid == lk_asid &&
      ((lk_vaddr[VA_W-1:MIN_SHIFT] ^ sel_ent.vpn) &
       ~{{(VPN_W-PPN_W){1'b0}}, pg_mask(sel_ent.size)}) == '0));
  a_r5_page_bits: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (((lk_paddr[PA_W-1:MIN_SHIFT] ^ sel_ent.ppn) & ~pg_mask(sel_ent.size)) == '0
                && lk_paddr[MIN_SHIFT-1:0] == lk_vaddr[MIN_SHIFT-1:0]));
  a_r6_quiet_without_hit: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (!lk_cacheable && !lk_wthru && lk_timing == '0 && lk_space == '0));
  a_r9_conflict_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    lk_attr_conflict |-> (lk_hit && lk_cacheable && !lk_wthru));
endmodule

// File: tb/sim_mmu_xlate_tlb.sv
`timescale 1ns/1ps
module sim_mmu_xlate_tlb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xlate_en = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic [7:0]  lk_asid = '0;
  logic        lk_hit, lk_miss, lk_cacheable, lk_wthru, lk_attr_conflict;
  logic [28:0] lk_paddr;
  logic [2:0]  lk_timing, lk_space;
  logic        wr_en = 1'b0, wr_valid = 1'b0, wr_cache = 1'b0, wr_wthru = 1'b0, wr_card = 1'b0;
  logic [1:0]  wr_idx = '0, wr_size = '0;
  logic [21:0] wr_vpn = '0;
  logic [7:0]  wr_asid = '0;
  logic [18:0] wr_ppn = '0;
  logic [2:0]  wr_timing = '0, wr_space = '0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mmu_xlate_tlb u0 (.*);

  // Behavioural reference: four records with byte-address bases.
  bit          m_v    [4];
  logic [31:0] m_va   [4];
  logic [28:0] m_pa   [4];
  logic [7:0]  m_as   [4];
  int          m_sz   [4];
  bit          m_c [4], m_w [4], m_k [4];
  logic [2:0]  m_t [4], m_s [4];

  function automatic int shift_of(int s);
    case (s)
      0: return 10;
      1: return 12;
      2: return 16;
      default: return 20;
    endcase
  endfunction

  task automatic chk(string tag);
    logic [39:0] exp_v, act_v;
    int    sel = -1;
    logic [31:0] lo;
    logic [28:0] pa;
    for (int i = 3; i >= 0; i--) begin
      int sh = shift_of(m_sz[i]);
      if (m_v[i] && m_as[i] == lk_asid && (lk_vaddr >> sh) == (m_va[i] >> sh)) sel = i;
    end
    if (!xlate_en) exp_v = {2'b00, lk_vaddr[28:0], 9'd0};
    else if (sel < 0) exp_v = {2'b01, 29'd0, 9'd0};
    else begin
      lo = (32'd1 << shift_of(m_sz[sel])) - 32'd1;
      pa = (m_pa[sel] & ~lo[28:0]) | (lk_vaddr[28:0] & lo[28:0]);
      exp_v = {2'b10, pa, m_c[sel], m_w[sel], m_t[sel], m_s[sel],
               m_k[sel] & m_c[sel] & ~m_w[sel]};
    end
    act_v = {lk_hit, lk_miss, lk_paddr, lk_cacheable, lk_wthru, lk_timing, lk_space, lk_attr_conflict};
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s va=%h asid=%h en=%0b actual=%h expected=%h", tag, lk_vaddr, lk_asid, xlate_en, act_v, exp_v);
    end
  endtask

  task automatic look(bit en, logic [31:0] va, logic [7:0] as, string tag);
    @(negedge clk);
    xlate_en = en; lk_vaddr = va; lk_asid = as;
    #5 chk(tag);
  endtask

  task automatic wr(int idx, bit v, logic [31:0] va, logic [7:0] as, int sz,
                    logic [28:0] pa, bit c, bit w, bit k, logic [2:0] t, logic [2:0] s);
    @(negedge clk);
    wr_en = 1; wr_idx = idx[1:0]; wr_valid = v; wr_vpn = va[31:10]; wr_asid = as;
    wr_size = sz[1:0]; wr_ppn = pa[28:10]; wr_cache = c; wr_wthru = w; wr_card = k;
    wr_timing = t; wr_space = s;
    #5 chk("R2 same-cycle lookup sees old entry");
    @(posedge clk);
    m_v[idx] = v; m_va[idx] = {va[31:10], 10'd0}; m_as[idx] = as; m_sz[idx] = sz;
    m_pa[idx] = {pa[28:10], 10'd0}; m_c[idx] = c; m_w[idx] = w; m_k[idx] = k;
    m_t[idx] = t; m_s[idx] = s;
    #1 wr_en = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin
      m_v[i] = 0; m_va[i] = 0; m_pa[i] = 0; m_as[i] = 0; m_sz[i] = 0;
      m_c[i] = 0; m_w[i] = 0; m_k[i] = 0; m_t[i] = 0; m_s[i] = 0;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    look(1, 32'h0000_0000, 8'h00, "R1 miss after reset");
    look(1, 32'h1234_5678, 8'h00, "R1 miss after reset");
    look(0, 32'hFEDC_BA98, 8'h00, "R8 bypass");

    // One entry of each size, all ASID 0x11.
    wr(0, 1, 32'h4000_0400, 8'h11, 0, 29'h0123_4400, 1, 0, 0, 3'd1, 3'd2);
    wr(1, 1, 32'h5000_3000, 8'h11, 1, 29'h0ABC_7000, 0, 1, 0, 3'd3, 3'd4);
    wr(2, 1, 32'h6001_0000, 8'h11, 2, 29'h1111_0000, 1, 1, 0, 3'd5, 3'd6);
    wr(3, 1, 32'h7010_0000, 8'h11, 3, 29'h1F30_0000, 1, 0, 1, 3'd7, 3'd7);

    look(1, 32'h4000_07FF, 8'h11, "R3 R5 R6 hit 1K");
    look(1, 32'h5000_3ABC, 8'h11, "R4 R5 hit 4K");
    look(1, 32'h6001_F00D, 8'h11, "R4 R5 hit 64K");
    look(1, 32'h701F_FFFF, 8'h11, "R4 R9 hit 1M card conflict");
    look(1, 32'h4000_07FF, 8'h12, "R3 asid mismatch");
    look(0, 32'h4000_07FF, 8'h11, "R8 bypass with entries");

    // Flip each bit near every boundary of every entry.
    for (int e = 0; e < 4; e++) begin
      for (int b = 8; b < 22; b++) begin
        logic [31:0] base;
        base = m_va[e] | 32'h0000_0011;
        look(1, base ^ (32'd1 << b), 8'h11, "R4 boundary sweep");
      end
    end

    // Conflict cleared by write-through, then by non-cacheable.
    wr(3, 1, 32'h7010_0000, 8'h11, 3, 29'h1F30_0000, 1, 1, 1, 3'd7, 3'd7);
    look(1, 32'h7012_3456, 8'h11, "R9 write-through clears conflict");
    wr(3, 1, 32'h7010_0000, 8'h11, 3, 29'h1F30_0000, 0, 0, 1, 3'd7, 3'd7);
    look(1, 32'h7012_3456, 8'h11, "R9 non-cacheable clears conflict");

    // Overlap: entry 2 (64K) and entry 1 (4K) on the same region.
    wr(1, 1, 32'h6001_3000, 8'h11, 1, 29'h0222_3000, 0, 1, 0, 3'd2, 3'd1);
    look(1, 32'h6001_3123, 8'h11, "R10 lowest index wins");
    look(1, 32'h6001_4123, 8'h11, "R10 only larger page");

    // Invalidate entry 0.
    wr(0, 0, 32'h4000_0400, 8'h11, 0, 29'h0123_4400, 1, 0, 0, 3'd1, 3'd2);
    look(1, 32'h4000_0500, 8'h11, "R11 invalidated entry misses");

    // Random fill and lookups.
    for (int r = 0; r < 6; r++) begin
      for (int i = 0; i < 4; i++) begin
        logic [31:0] rv, rp;
        rv = $urandom; rp = $urandom;
        wr(i, ($urandom % 5) != 0, rv, 8'($urandom % 3), int'($urandom % 4), rp[28:0],
           bit'($urandom), bit'($urandom), bit'($urandom), 3'($urandom), 3'($urandom));
      end
      for (int k = 0; k < 60; k++) begin
        int pick;
        logic [31:0] va;
        pick = int'($urandom % 5);
        va = $urandom;
        if (pick < 4) va = m_va[pick] ^ (va & ((32'd1 << (shift_of(m_sz[pick]) + 1)) - 1));
        look(($urandom % 8) != 0, va, 8'($urandom % 3), "R3 R6 R7 random");
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule